// File: doc/BRIEF.md
# Load Alignment and Lane Extraction Stage

This stage sits after the point where a 32-bit word comes back from memory or cache for a load. It takes the access width (byte, halfword or word), the two lowest address bits, the byte order and an alignment-check enable. From these it produces the loaded value, right-justified and zero-extended. When alignment checking is on, a word load with either low address bit set is reported as a fault. A halfword load with bit 0 set is reported as a fault too.

The lane is picked by one datapath that serves both byte orders. The byte index is the low address bits XORed with a constant that depends on the access width: 3 for a byte and 2 for a halfword, used only when big-endian. Requests enter on a valid/ready stream. Results leave one cycle later on a second valid/ready stream that has a single output register. An input beat is accepted when `in_valid && in_ready`. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output payload holds steady.

Top module: `load_lane_align`

## Requirements
- R1: Size code 2'b10 (word) returns the raw word unchanged when no fault occurs.
- R2: Size code 2'b00 (byte) returns raw[8*k+7:8*k] zero-extended, where k = addr[1:0] XOR (big ? 3 : 0).
- R3: Size code 2'b01 (halfword) returns raw[8*k+15:8*k] zero-extended, where k = (addr[1:0] & 2) XOR (big ? 2 : 0).
- R4: With align_chk=1, a word access with addr[1:0] != 0 faults. A halfword access with addr[0]=1 also faults. A byte access never faults.
- R5: With align_chk=0, no access faults, and a misaligned access still extracts lanes by the R2/R3 rules or returns the word unchanged.
- R6: A faulting beat presents out_data=0 with out_fault=1 in the same beat as out_valid.
- R7: Size code 2'b11 is handled as a word access and sets out_bad_size=1 on its output beat. Other codes give out_bad_size=0.
- R8: An accepted input beat appears on the output on the next clock edge (one-cycle latency).
- R9: While out_valid=1 and out_ready=0, the output payload is stable and in_ready=0.
- R10: After reset, out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_size | input | 2 | 00 byte, 01 half, 10 word, 11 illegal |
| in_addr | input | 2 | Low address bits |
| in_big | input | 1 | 1 = big-endian lane order |
| in_align_chk | input | 1 | Enable alignment faults |
| in_raw | input | 32 | Word from memory/cache |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 32 | Extracted zero-extended value |
| out_fault | output | 1 | Alignment fault for this beat |
| out_bad_size | output | 1 | Illegal size code seen |

## Verification
The assertions assume a well-behaved consumer: out_ready is a defined level every cycle. They also assume the producer holds its payload steady only by choice; no protocol rule is placed on the input side. The stall and payload-stability properties therefore check only what the stage itself must hold. The bench drives every input from tasks between clock edges, keeps out_ready low only inside the back-pressure scenario, and samples outputs at the falling edge.

// File: rtl/lla_pkg.sv
package lla_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [31:0] data;
    logic        fault;
    logic        bad_size;
  } lla_result_t;
endpackage

// File: rtl/lla_misalign.sv
module lla_misalign
  import lla_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] addr,
  input  logic       chk,
  output logic       fault
);
  always_comb begin
    fault = 1'b0;
    if (chk) begin
      unique case (size)
        SZ_HALF: fault = addr[0];
        SZ_BYTE: fault = 1'b0;
        default: fault = |addr;
      endcase
    end
  end
endmodule

// File: rtl/lla_lane_pick.sv
module lla_lane_pick
  import lla_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   size,
  input  logic [1:0]   addr,
  input  logic         big,
  input  logic [W-1:0] raw,
  output logic [W-1:0] value
);
  localparam int SHW = $clog2(W);
  logic [1:0]     lane;
  logic [SHW-1:0] shamt;
  logic [W-1:0]   shifted;

  always_comb begin
    unique case (size)
      SZ_BYTE: lane = addr ^ {big, big};
      SZ_HALF: lane = (addr & 2'b10) ^ {big, 1'b0};
      default: lane = 2'b00;
    endcase
    shamt   = SHW'({lane, 3'b000});
    shifted = raw >> shamt;
    unique case (size)
      SZ_BYTE: value = {{(W-8){1'b0}},  shifted[7:0]};
      SZ_HALF: value = {{(W-16){1'b0}}, shifted[15:0]};
      default: value = raw;
    endcase
  end
endmodule

// File: rtl/lla_out_reg.sv
module lla_out_reg
  import lla_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  lla_result_t in_res,
  output logic        out_valid,
  input  logic        out_ready,
  output lla_result_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end
endmodule

// File: rtl/load_lane_align.sv
module load_lane_align
  import lla_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_size,
  input  logic [1:0]   in_addr,
  input  logic         in_big,
  input  logic         in_align_chk,
  input  logic [W-1:0] in_raw,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_fault,
  output logic         out_bad_size
);
  logic        flt;
  logic [W-1:0] val;
  lla_result_t nxt, cur;

  lla_misalign u_mis (.size(in_size), .addr(in_addr), .chk(in_align_chk), .fault(flt));

  lla_lane_pick #(.W(W)) u_pick (
    .size(in_size), .addr(in_addr), .big(in_big), .raw(in_raw), .value(val)
  );

  always_comb begin
    nxt.data     = flt ? '0 : 32'(val);
    nxt.fault    = flt;
    nxt.bad_size = (in_size == SZ_BAD);
  end

  lla_out_reg u_reg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_res(nxt), .out_valid(out_valid), .out_ready(out_ready), .out_res(cur)
  );

  assign out_data     = W'(cur.data);
  assign out_fault    = cur.fault;
  assign out_bad_size = cur.bad_size;
endmodule

// File: rtl/load_lane_align_chk.sv
module load_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_size,
  input logic [1:0]  in_addr,
  input logic        in_align_chk,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_fault,
  input logic        out_bad_size
);
  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_data == 32'd0));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fault) && $stable(out_bad_size)));
  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R4
  word_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_align_chk && in_size == 2'b10 && in_addr != 2'b00) |=> out_fault);
  // R5
  nochk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_align_chk) |=> !out_fault);
  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_bad_size == ($past(in_size) == 2'b11)));
endmodule

bind load_lane_align load_lane_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_size(in_size), .in_addr(in_addr), .in_align_chk(in_align_chk),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_fault(out_fault), .out_bad_size(out_bad_size)
);

// File: tb/sim_load_lane_align.sv
`timescale 1ns/1ps
module sim_load_lane_align;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_big = 1'b0, in_align_chk = 1'b0;
  logic [1:0] in_size = 2'b10, in_addr = 2'b00;
  logic [31:0] in_raw = '0, out_data;
  logic out_valid, out_ready = 1'b1, out_fault, out_bad_size;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  load_lane_align u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] sz, input logic [1:0] a,
                                        input logic big, input logic [31:0] raw);
    int k;
    if (sz == 2'b00) begin
      k = int'(a ^ (big ? 2'd3 : 2'd0));
      return {24'd0, raw[8*k +: 8]};
    end else if (sz == 2'b01) begin
      k = int'((a & 2'b10) ^ (big ? 2'd2 : 2'd0));
      return {16'd0, raw[8*k +: 16]};
    end
    return raw;
  endfunction

  // drive one beat, check on the next falling edge
  task automatic beat(input string req, input logic [1:0] sz, input logic [1:0] a, input logic big,
                      input logic ac, input logic [31:0] raw, input logic [31:0] exp_d,
                      input logic exp_f, input logic exp_b);
    @(negedge clk);
    in_valid = 1'b1; in_size = sz; in_addr = a; in_big = big; in_align_chk = ac; in_raw = raw;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " data"}, out_data, exp_d);
    chk({req, " fault"}, {31'd0, out_fault}, {31'd0, exp_f});
    chk({req, " badsz"}, {31'd0, out_bad_size}, {31'd0, exp_b});
  endtask

  task automatic t_reset;  // R10
    chk("R10 reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_word;  // R1
    beat("R1", 2'b10, 2'b00, 1'b0, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b0);
    beat("R1", 2'b10, 2'b00, 1'b1, 1'b1, 32'h01234567, 32'h01234567, 1'b0, 1'b0);
  endtask

  task automatic t_bytes;  // R2
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 2; b++)
        beat("R2", 2'b00, 2'(a), 1'(b), 1'b1, 32'hA1B2C3D4,
             model(2'b00, 2'(a), 1'(b), 32'hA1B2C3D4), 1'b0, 1'b0);
  endtask

  task automatic t_halves;  // R3
    for (int a = 0; a < 4; a += 2)
      for (int b = 0; b < 2; b++)
        beat("R3", 2'b01, 2'(a), 1'(b), 1'b1, 32'h8899AABB,
             model(2'b01, 2'(a), 1'(b), 32'h8899AABB), 1'b0, 1'b0);
  endtask

  task automatic t_faults;  // R4 R6
    beat("R4 word", 2'b10, 2'b01, 1'b0, 1'b1, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0);
    beat("R4 word", 2'b10, 2'b10, 1'b1, 1'b1, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0);
    beat("R4 half", 2'b01, 2'b11, 1'b0, 1'b1, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0);
    beat("R6 byte nofault", 2'b00, 2'b11, 1'b0, 1'b1, 32'h5A000000, 32'h5A, 1'b0, 1'b0);
  endtask

  task automatic t_nochk;  // R5
    beat("R5 word", 2'b10, 2'b11, 1'b0, 1'b0, 32'hCAFEF00D, 32'hCAFEF00D, 1'b0, 1'b0);
    beat("R5 half", 2'b01, 2'b11, 1'b0, 1'b0, 32'h11223344, 32'h1122, 1'b0, 1'b0);
    beat("R5 halfbig", 2'b01, 2'b01, 1'b1, 1'b0, 32'h11223344, 32'h1122, 1'b0, 1'b0);
  endtask

  task automatic t_badsize;  // R7
    beat("R7", 2'b11, 2'b00, 1'b0, 1'b1, 32'h13579BDF, 32'h13579BDF, 1'b0, 1'b1);
    beat("R7 misal", 2'b11, 2'b10, 1'b0, 1'b1, 32'h13579BDF, 32'd0, 1'b1, 1'b1);
  endtask

  task automatic t_stall;  // R8 R9
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_size = 2'b00; in_addr = 2'b01; in_big = 1'b0; in_align_chk = 1'b1; in_raw = 32'h00AB0000;
    @(negedge clk);
    chk("R8 latency", {31'd0, out_valid}, 32'd1);
    chk("R9 ready low", {31'd0, in_ready}, 32'd0);
    in_raw = 32'h00000077; in_addr = 2'b00;
    @(negedge clk);
    chk("R9 hold", out_data, 32'h00000000);
    @(negedge clk);
    chk("R9 hold2", out_data, 32'h00000000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next", out_data, 32'h77);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word(); t_bytes(); t_halves(); t_faults(); t_nochk(); t_badsize(); t_stall();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule